// File: doc/BRIEF.md
# Paired-Page Translation Lookaside Buffer

This block translates virtual addresses to physical addresses. It holds a configurable number of fully associative entries, 48 by default. Each entry describes a pair of adjacent virtual pages that share one tag. Each entry stores:

- a page mask that sets the page size;
- a tag made of the virtual page-pair number, an address-space identifier and a global flag;
- two low words, one for the even page of the pair and one for the odd page.

Every low word carries a valid bit, a three-bit coherency code and a page frame number counted in 4 KiB units.

A lookup is driven by three inputs: a virtual address, the current address-space identifier and an addressing-mode select for 32-bit or 64-bit mode. The lookup is combinational. It returns a hit flag, the physical address, a cacheable flag and the index of the entry that matched. A parameter can add one output register stage to the result. Entries are loaded one at a time through a separate write port that is clocked.

The entry with the lowest index whose tag matches decides the result. If the half it selects is invalid, the lookup is a miss and no later entry is considered. Raising exceptions, refilling entries and checking permissions are left to the logic around this block.

Top module: `paired_tlb`

## Requirements
- R1: After reset every entry is cleared, so both of its halves are invalid. A lookup then returns hit 0, physical address 0, cacheable 0 and index 0.
- R2: When wr_en is high at a rising clock edge and wr_idx is below the entry count, the entry at wr_idx takes the written values. The change is visible to lookups from the next cycle. A write with wr_idx at or above the entry count changes no entry.
- R3: The tag compare ignores virtual address bits 12:0 and every bit set in the entry's page mask. With mask 0x6000, addresses that differ only in bits 14:0 match the same entry.
- R4: A tag-matching entry is selected only when its global flag is set or when its stored identifier equals lk_asid.
- R5: When lk_mode64 is 0, only virtual address bits 31:13 take part in the compare. When lk_mode64 is 1, bits VA_W-1:13 take part.
- R6: The page size is (mask + 0x2000) >> 1. If the virtual address bit at that size is 0, the even low word (wr_lo0) is used; if it is 1, the odd low word (wr_lo1) is used.
- R7: If the selected low word has its valid bit (bit 0) clear, the lookup misses. Entries with higher indices are not searched, even if they would match.
- R8: The physical address is pfn × 4096 plus (virtual address AND (page size − 1)), then ANDed with PA_BUS_MASK. The pfn is bits PFN_W+3:4 of the low word.
- R9: On a hit, cacheable is 1 unless the coherency code (low-word bits 3:1) equals 2. On a miss, cacheable is 0.
- R10: When several entries match, the one with the lowest index decides the result, and that index is reported on hit_idx.
- R11: On a miss, hit is 0 and the physical address and index outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for one entry |
| wr_idx | input | IDX_W | Entry index to write |
| wr_mask | input | VA_W | Page mask (bits 12:0 are ignored) |
| wr_vpn | input | VA_W | Virtual page-pair address |
| wr_asid | input | ASID_W | Address-space identifier of the entry |
| wr_glob | input | 1 | Global flag; matches any identifier |
| wr_lo0 | input | LO_W | Even low word {pfn, coh[2:0], valid} |
| wr_lo1 | input | LO_W | Odd low word {pfn, coh[2:0], valid} |
| lk_va | input | VA_W | Virtual address to translate |
| lk_asid | input | ASID_W | Current address-space identifier |
| lk_mode64 | input | 1 | 1 selects 64-bit addressing |
| hit | output | 1 | Translation found |
| pa | output | PA_W | Physical address |
| cacheable | output | 1 | Selected page is cacheable |
| hit_idx | output | IDX_W | Index of the matching entry |

## Verification
The bench loads two global entries that cover the same page pair, with the odd half of the lower-index entry invalid. A design that keeps searching after an invalid half would report a hit from the higher entry instead of a miss. A design that ignored index priority would report the wrong index.

An entry whose tag has bits set above bit 31 is looked up in both addressing modes. A design that compares the full width in 32-bit mode would miss there.

A frame number whose top bits lie outside the bus mask shows whether the mask is applied. Addresses on both sides of the pair-select bit, with 4 KiB and 16 KiB pages, show whether even and odd halves are chosen correctly and whether the offset width is right.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;
    // low-word layout: {pfn, coherency, valid}
    localparam int LO_VALID_BIT = 0;
    localparam int COH_W        = 3;
    localparam int LO_COH_LSB   = 1;
    localparam int LO_PFN_LSB   = LO_COH_LSB + COH_W;
    localparam int FRAME_SHIFT  = 12;
    localparam int PAIR_SHIFT   = 13;
    localparam logic [COH_W-1:0] COH_UNCACHED = 3'd2;

    typedef enum logic {
        MODE_32 = 1'b0,
        MODE_64 = 1'b1
    } addr_mode_e;
endpackage

// File: rtl/ptlb_entry_store.sv
module ptlb_entry_store #(
    parameter int N      = 48,
    parameter int VA_W   = 44,
    parameter int ASID_W = 8,
    parameter int LO_W   = 28,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VA_W-1:0]   wr_mask,
    input  logic [VA_W-1:0]   wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_glob,
    input  logic [LO_W-1:0]   wr_lo0,
    input  logic [LO_W-1:0]   wr_lo1,
    output logic [VA_W-1:0]   e_mask [N],
    output logic [VA_W-1:0]   e_tag  [N],
    output logic [ASID_W-1:0] e_asid [N],
    output logic              e_glob [N],
    output logic [LO_W-1:0]   e_lo0  [N],
    output logic [LO_W-1:0]   e_lo1  [N]
);
    import ptlb_pkg::*;

    localparam logic [VA_W-1:0] LOW_BITS = VA_W'((64'd1 << PAIR_SHIFT) - 64'd1);

    logic [VA_W-1:0] mask_c;
    logic            idx_ok;

    assign mask_c = wr_mask & ~LOW_BITS;
    assign idx_ok = (int'(wr_idx) < N);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                e_mask[i] <= '0;
                e_tag[i]  <= '0;
                e_asid[i] <= '0;
                e_glob[i] <= 1'b0;
                e_lo0[i]  <= '0;
                e_lo1[i]  <= '0;
            end
        end else if (wr_en && idx_ok) begin
            e_mask[wr_idx] <= mask_c;
            e_tag[wr_idx]  <= wr_vpn & ~(mask_c | LOW_BITS);
            e_asid[wr_idx] <= wr_asid;
            e_glob[wr_idx] <= wr_glob;
            e_lo0[wr_idx]  <= wr_lo0;
            e_lo1[wr_idx]  <= wr_lo1;
        end
    end

    AST_STORED_MASK_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (e_mask[0] & LOW_BITS) == '0); // R3
endmodule

// File: rtl/ptlb_match.sv
module ptlb_match #(
    parameter int N      = 48,
    parameter int VA_W   = 44,
    parameter int ASID_W = 8
) (
    input  logic [VA_W-1:0]   va,
    input  logic [ASID_W-1:0] asid,
    input  logic              mode64,
    input  logic [VA_W-1:0]   e_mask [N],
    input  logic [VA_W-1:0]   e_tag  [N],
    input  logic [ASID_W-1:0] e_asid [N],
    input  logic              e_glob [N],
    output logic [N-1:0]      match,
    output logic [N-1:0]      odd
);
    import ptlb_pkg::*;

    localparam logic [VA_W-1:0] LOW_BITS  = VA_W'((64'd1 << PAIR_SHIFT) - 64'd1);
    localparam logic [VA_W-1:0] PAIR_UNIT = VA_W'(64'd1 << PAIR_SHIFT);
    localparam logic [VA_W-1:0] NARROW    = VA_W'(64'hFFFF_FFFF);

    logic [VA_W-1:0] mode_keep;
    assign mode_keep = (addr_mode_e'(mode64) == MODE_64) ? '1 : NARROW;

    for (genvar g = 0; g < N; g++) begin : g_ent
        logic [VA_W-1:0] keep;
        logic [VA_W-1:0] half;
        logic            tag_eq;
        assign keep     = ~(e_mask[g] + LOW_BITS) & mode_keep;
        assign half     = (e_mask[g] + PAIR_UNIT) >> 1;
        assign tag_eq   = (((va ^ e_tag[g]) & keep) == '0);
        assign match[g] = tag_eq && (e_glob[g] || (e_asid[g] == asid));
        assign odd[g]   = |(va & half);
    end
endmodule

// File: rtl/ptlb_select.sv
module ptlb_select #(
    parameter int N      = 48,
    parameter int VA_W   = 44,
    parameter int PA_W   = 36,
    parameter int PFN_W  = 24,
    parameter int LO_W   = 28,
    parameter int IDX_W  = 6,
    parameter logic [PA_W-1:0] PA_BUS_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VA_W-1:0]   va,
    input  logic [N-1:0]      match,
    input  logic [N-1:0]      odd,
    input  logic [VA_W-1:0]   e_mask [N],
    input  logic [LO_W-1:0]   e_lo0  [N],
    input  logic [LO_W-1:0]   e_lo1  [N],
    output logic              hit,
    output logic [PA_W-1:0]   pa,
    output logic              cacheable,
    output logic [IDX_W-1:0]  idx
);
    import ptlb_pkg::*;

    localparam logic [VA_W-1:0] PAIR_UNIT = VA_W'(64'd1 << PAIR_SHIFT);

    logic             found;
    logic [IDX_W-1:0] sel;
    logic [N-1:0]     first_oh;
    logic [LO_W-1:0]  lo;
    logic [VA_W-1:0]  size;
    logic [VA_W-1:0]  off;
    logic [PA_W-1:0]  base;
    logic [PA_W-1:0]  pa_raw;
    logic [COH_W-1:0] coh;

    // lowest index wins: scan downward so the last assignment is the lowest
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                found = 1'b1;
                sel   = IDX_W'(i);
            end
        end
    end

    always_comb begin
        logic taken;
        taken = 1'b0;
        for (int i = 0; i < N; i++) begin
            first_oh[i] = match[i] && !taken;
            taken       = taken || match[i];
        end
    end

    assign lo     = odd[sel] ? e_lo1[sel] : e_lo0[sel];
    assign coh    = lo[LO_COH_LSB +: COH_W];
    assign size   = (e_mask[sel] + PAIR_UNIT) >> 1;
    assign off    = va & (size - 1'b1);
    assign base   = PA_W'(lo[LO_PFN_LSB +: PFN_W]) << FRAME_SHIFT;
    assign pa_raw = (base + PA_W'(off)) & PA_BUS_MASK;

    always_comb begin
        hit       = found && lo[LO_VALID_BIT];
        pa        = hit ? pa_raw : '0;
        cacheable = hit && (coh != COH_UNCACHED);
        idx       = hit ? sel : '0;
    end

    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(first_oh)); // R10
    AST_WINNER_IS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> first_oh[sel]); // R10
    AST_HIT_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (match != '0)); // R7
endmodule

// File: rtl/paired_tlb.sv
module paired_tlb #(
    parameter int N       = 48,
    parameter int VA_W    = 44,
    parameter int PA_W    = 36,
    parameter int ASID_W  = 8,
    parameter int PFN_W   = 24,
    parameter bit OUT_REG = 1'b0,
    parameter logic [PA_W-1:0] PA_BUS_MASK = 36'h0_FFFF_FFFF,
    localparam int IDX_W  = $clog2(N),
    localparam int LO_W   = PFN_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VA_W-1:0]   wr_mask,
    input  logic [VA_W-1:0]   wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_glob,
    input  logic [LO_W-1:0]   wr_lo0,
    input  logic [LO_W-1:0]   wr_lo1,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_mode64,
    output logic              hit,
    output logic [PA_W-1:0]   pa,
    output logic              cacheable,
    output logic [IDX_W-1:0]  hit_idx
);
    logic [VA_W-1:0]   e_mask [N];
    logic [VA_W-1:0]   e_tag  [N];
    logic [ASID_W-1:0] e_asid [N];
    logic              e_glob [N];
    logic [LO_W-1:0]   e_lo0  [N];
    logic [LO_W-1:0]   e_lo1  [N];
    logic [N-1:0]      match;
    logic [N-1:0]      odd;
    logic              c_hit, c_cache;
    logic [PA_W-1:0]   c_pa;
    logic [IDX_W-1:0]  c_idx;

    ptlb_entry_store #(.N(N), .VA_W(VA_W), .ASID_W(ASID_W), .LO_W(LO_W), .IDX_W(IDX_W)) store_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_mask(wr_mask),
        .wr_vpn(wr_vpn), .wr_asid(wr_asid), .wr_glob(wr_glob), .wr_lo0(wr_lo0), .wr_lo1(wr_lo1),
        .e_mask(e_mask), .e_tag(e_tag), .e_asid(e_asid), .e_glob(e_glob),
        .e_lo0(e_lo0), .e_lo1(e_lo1));

    ptlb_match #(.N(N), .VA_W(VA_W), .ASID_W(ASID_W)) match_i (
        .va(lk_va), .asid(lk_asid), .mode64(lk_mode64),
        .e_mask(e_mask), .e_tag(e_tag), .e_asid(e_asid), .e_glob(e_glob),
        .match(match), .odd(odd));

    ptlb_select #(.N(N), .VA_W(VA_W), .PA_W(PA_W), .PFN_W(PFN_W), .LO_W(LO_W),
                  .IDX_W(IDX_W), .PA_BUS_MASK(PA_BUS_MASK)) select_i (
        .clk(clk), .rst_n(rst_n), .va(lk_va), .match(match), .odd(odd),
        .e_mask(e_mask), .e_lo0(e_lo0), .e_lo1(e_lo1),
        .hit(c_hit), .pa(c_pa), .cacheable(c_cache), .idx(c_idx));

    if (OUT_REG) begin : g_oreg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hit       <= 1'b0;
                pa        <= '0;
                cacheable <= 1'b0;
                hit_idx   <= '0;
            end else begin
                hit       <= c_hit;
                pa        <= c_pa;
                cacheable <= c_cache;
                hit_idx   <= c_idx;
            end
        end
    end else begin : g_comb
        assign hit       = c_hit;
        assign pa        = c_pa;
        assign cacheable = c_cache;
        assign hit_idx   = c_idx;
    end

    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (pa == '0 && !cacheable && hit_idx == '0)); // R11
    AST_PA_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (pa & ~PA_BUS_MASK) == '0); // R8
    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (int'(hit_idx) < N)); // R10
endmodule

// File: tb/paired_tlb_tb_top.sv
module paired_tlb_tb_top;
    localparam int N = 48, VA_W = 44, PA_W = 36, ASID_W = 8, PFN_W = 24;
    localparam int IDX_W = $clog2(N), LO_W = PFN_W + 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0, wr_glob = 1'b0, lk_mode64 = 1'b0;
    logic [IDX_W-1:0] wr_idx = '0;
    logic [VA_W-1:0] wr_mask = '0, wr_vpn = '0, lk_va = '0;
    logic [ASID_W-1:0] wr_asid = '0, lk_asid = '0;
    logic [LO_W-1:0] wr_lo0 = '0, wr_lo1 = '0;
    logic hit, cacheable;
    logic [PA_W-1:0] pa;
    logic [IDX_W-1:0] hit_idx;
    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    paired_tlb dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_mask(wr_mask),
        .wr_vpn(wr_vpn), .wr_asid(wr_asid), .wr_glob(wr_glob), .wr_lo0(wr_lo0), .wr_lo1(wr_lo1),
        .lk_va(lk_va), .lk_asid(lk_asid), .lk_mode64(lk_mode64),
        .hit(hit), .pa(pa), .cacheable(cacheable), .hit_idx(hit_idx));

    function automatic logic [LO_W-1:0] mk_lo(input logic [PFN_W-1:0] pfn, input logic [2:0] coh, input logic v);
        return {pfn, coh, v};
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic write_ent(input int idx, input logic [VA_W-1:0] mask, input logic [VA_W-1:0] vpn,
                             input logic [ASID_W-1:0] asid, input logic glob,
                             input logic [LO_W-1:0] lo0, input logic [LO_W-1:0] lo1);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_mask = mask; wr_vpn = vpn;
        wr_asid = asid; wr_glob = glob; wr_lo0 = lo0; wr_lo1 = lo1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input string req, input logic [VA_W-1:0] va, input logic [ASID_W-1:0] asid,
                        input logic m64, input logic e_hit, input logic [PA_W-1:0] e_pa,
                        input logic e_cache, input int e_idx);
        @(negedge clk);
        lk_va = va; lk_asid = asid; lk_mode64 = m64;
        #2;
        chk(req, "hit", 64'(hit), 64'(e_hit));
        chk(req, "pa", 64'(pa), 64'(e_pa));
        chk(req, "cacheable", 64'(cacheable), 64'(e_cache));
        chk(req, "hit_idx", 64'(hit_idx), 64'(e_idx));
    endtask

    task automatic t_reset();   // R1
        look("R1", 44'h0, 8'h00, 1'b0, 1'b0, 36'h0, 1'b0, 0);
    endtask

    task automatic t_even_odd(); // R6 R8 R9
        write_ent(5, 44'h0, 44'h0_0040_0000, 8'h11, 1'b0, mk_lo(24'h000123, 3'd3, 1'b1), mk_lo(24'h000456, 3'd2, 1'b1));
        look("R6", 44'h0_0040_0ABC, 8'h11, 1'b0, 1'b1, 36'h0_0012_3ABC, 1'b1, 5);
        look("R9", 44'h0_0040_1ABC, 8'h11, 1'b0, 1'b1, 36'h0_0045_6ABC, 1'b0, 5);
    endtask

    task automatic t_asid();     // R4 R11
        look("R4", 44'h0_0040_0ABC, 8'h12, 1'b0, 1'b0, 36'h0, 1'b0, 0);
    endtask

    task automatic t_big_page_priority(); // R3 R7 R10
        write_ent(9, 44'h6000, 44'h0_1000_0000, 8'h22, 1'b1, mk_lo(24'h00A000, 3'd3, 1'b1), mk_lo(24'h0, 3'd3, 1'b0));
        write_ent(20, 44'h6000, 44'h0_1000_0000, 8'h22, 1'b1, mk_lo(24'h00B000, 3'd3, 1'b1), mk_lo(24'h00C000, 3'd3, 1'b1));
        look("R3", 44'h0_1000_2345, 8'h77, 1'b0, 1'b1, 36'h0_0A00_2345, 1'b1, 9);
        look("R10", 44'h0_1000_1000, 8'h77, 1'b0, 1'b1, 36'h0_0A00_1000, 1'b1, 9);
        look("R7", 44'h0_1000_6000, 8'h77, 1'b0, 1'b0, 36'h0, 1'b0, 0);
    endtask

    task automatic t_mode();     // R5
        write_ent(12, 44'h0, 44'h5_0030_0000, 8'h33, 1'b0, mk_lo(24'h000777, 3'd3, 1'b1), mk_lo(24'h0, 3'd3, 1'b0));
        look("R5", 44'h0_0030_0010, 8'h33, 1'b0, 1'b1, 36'h0_0077_7010, 1'b1, 12);
        look("R5", 44'h0_0030_0010, 8'h33, 1'b1, 1'b0, 36'h0, 1'b0, 0);
        look("R5", 44'h5_0030_0010, 8'h33, 1'b1, 1'b1, 36'h0_0077_7010, 1'b1, 12);
    endtask

    task automatic t_bus_mask(); // R8
        write_ent(30, 44'h0, 44'h0_0060_0000, 8'h44, 1'b0, mk_lo(24'hF12345, 3'd0, 1'b1), mk_lo(24'h0, 3'd0, 1'b0));
        look("R8", 44'h0_0060_0FFF, 8'h44, 1'b0, 1'b1, 36'h0_1234_5FFF, 1'b1, 30);
    endtask

    task automatic t_writes();   // R2
        write_ent(50, 44'h0, 44'h0_0070_0000, 8'h55, 1'b0, mk_lo(24'h000888, 3'd3, 1'b1), mk_lo(24'h000888, 3'd3, 1'b1));
        look("R2", 44'h0_0070_0000, 8'h55, 1'b0, 1'b0, 36'h0, 1'b0, 0);
        write_ent(5, 44'h0, 44'h0_0040_0000, 8'h11, 1'b0, mk_lo(24'h0, 3'd3, 1'b0), mk_lo(24'h0, 3'd3, 1'b0));
        look("R2", 44'h0_0040_0ABC, 8'h11, 1'b0, 1'b0, 36'h0, 1'b0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_even_odd();
        t_asid();
        t_big_page_priority();
        t_mode();
        t_bus_mask();
        t_writes();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule